// File: doc/BRIEF.md
# DMA Burst Length Planner

The planner takes one frame-data transfer from a DMA engine and cuts it into system bus transactions. Each request gives a word-aligned start byte address, a byte count, a flag that marks the transfer as the tail of a packet or buffer, a direction (read for the transmit path, write for the receive path), a 5-bit burst-length code and a force-full-burst enable. The planner then issues a series of transactions through a valid/ready handshake. Each transaction carries a start address, a beat count, a burst type (single or incrementing), the byte enables of its final beat and, for forced bursts, the number of bytes that lie past the real data.

The data path is 32 bits wide, so one beat moves 4 bytes. In normal operation the planner issues the configured burst only when at least a full burst of data remains and the burst ends at or before the next 1 KB address boundary. In every other case it issues one single beat and looks again. When force-full-burst is set and the request marks the tail of a packet or buffer, the short tail goes out as a single full-length burst. On a write the excess bytes are filled with zeros. On a read the excess bytes are dropped. This happens only if that burst stays inside the current 1 KB window.

Top module: `dma_burst_planner`

## Requirements
- R1: Burst code 1 selects single-beat transactions only. Codes 4, 8 and 16 select incrementing bursts of 4, 8 and 16 beats (4 bytes per beat). The code is sampled when the request is accepted.
- R2: Any other code, reserved values 0 and 2 included, is handled exactly as code 1, and the `cfg_err` output goes to 1 and stays at 1 until reset.
- R3: In normal operation a transaction is a full configured burst (`txn_incr`=1) only if the remaining bytes are at least beats×4 and the address low ten bits plus beats×4 is no more than 1024. Otherwise the transaction is one beat (`txn_beats`=1, `txn_incr`=0) carrying min(remaining, 4) bytes.
- R4: When `cfg_force_max`=1 and `req_last`=1 and fewer than beats×4 bytes remain, the remaining data goes out as one full configured burst that is also the final transaction. `txn_pad_bytes` equals beats×4 minus the remaining bytes. In every other case `txn_pad_bytes` is 0.
- R5: A forced burst on a write (`req_write`=1) raises `txn_zero_fill`, which means every padding byte is written as 0x00. A forced burst on a read raises `txn_discard`, which means the excess read data is dropped. Both signals are 0 on all other transactions.
- R6: A forced burst is never issued if it would cross a 1 KB boundary. Such a tail follows the rules of R3.
- R7: `txn_last_be` bit i marks byte lane i (lane 0 is the lowest address) of the transaction's last beat as real data. It is 4'b0000 when that beat holds only padding.
- R8: The first transaction starts at the request address. Each following transaction starts at the previous address plus beats×4. The sum of real bytes over all transactions equals the request length. `txn_final` marks the last transaction.
- R9: While `txn_valid`=1 and `txn_ready`=0, the transaction fields hold their values.
- R10: `req_ready` is 1 only when no transaction is pending. `done` is 1 for one cycle, in the cycle after the final handshake. A zero-length request produces no transaction and raises `done` in the cycle after it is accepted.
- R11: After reset, `req_ready`=1 and `txn_valid`, `done` and `cfg_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Planner idle, request accepted |
| req_addr | input | ADDR_W | Word-aligned start byte address |
| req_len | input | LEN_W | Transfer length in bytes |
| req_last | input | 1 | Transfer is the tail of a packet or buffer |
| req_write | input | 1 | 1 = write (receive path), 0 = read (transmit path) |
| cfg_burst_code | input | 5 | Burst-length code |
| cfg_force_max | input | 1 | Force full-length burst on the tail |
| txn_valid | output | 1 | Transaction present |
| txn_ready | input | 1 | Transaction taken |
| txn_addr | output | ADDR_W | Transaction start address |
| txn_beats | output | 5 | Beat count |
| txn_incr | output | 1 | 1 = incrementing burst, 0 = single |
| txn_last_be | output | 4 | Real-data byte lanes of the last beat |
| txn_pad_bytes | output | 7 | Bytes past the real data in a forced burst |
| txn_zero_fill | output | 1 | Padding bytes written as 0x00 |
| txn_discard | output | 1 | Excess read bytes dropped |
| txn_final | output | 1 | Last transaction of the request |
| done | output | 1 | One-cycle pulse when a request completes |
| cfg_err | output | 1 | Sticky flag: an invalid burst code was seen |

## Verification
Random requests mix all four legal codes, lengths that do and do not fill whole bursts, start addresses just below a 1 KB boundary, both directions and all combinations of tail and force flags. This separates full bursts from single-beat fallback and forced bursts from normal tails. Directed cases isolate a forced burst that would cross a boundary (it must fall back to singles), a forced write and a forced read with a 5-byte tail (padding versus dropped data, last beat all padding), zero-length requests, and reserved codes that must give singles and the sticky error. A random ready signal stalls transactions to expose fields that change while waiting.

// File: rtl/bplan_pkg.sv
package bplan_pkg;
    localparam int BEAT_BYTES = 4;
    localparam int BOUND_BITS = 10;
    localparam int CODE_W     = 5;
    localparam int BEATS_W    = 5;
    localparam int SPAN_W     = BEATS_W + $clog2(BEAT_BYTES);

    typedef enum logic [1:0] {
        K_SINGLE = 2'd0,
        K_BURST  = 2'd1,
        K_FORCED = 2'd2
    } kind_e;
endpackage

// File: rtl/bplan_code_decode.sv
module bplan_code_decode
    import bplan_pkg::*;
(
    input  logic [CODE_W-1:0]  code,
    output logic [BEATS_W-1:0] beats,
    output logic               legal
);
    always_comb begin
        beats = BEATS_W'(1);
        legal = 1'b0;
        case (code)
            CODE_W'(1):  begin beats = BEATS_W'(1);  legal = 1'b1; end
            CODE_W'(4):  begin beats = BEATS_W'(4);  legal = 1'b1; end
            CODE_W'(8):  begin beats = BEATS_W'(8);  legal = 1'b1; end
            CODE_W'(16): begin beats = BEATS_W'(16); legal = 1'b1; end
            default:     begin beats = BEATS_W'(1);  legal = 1'b0; end
        endcase
    end
endmodule

// File: rtl/bplan_txn_calc.sv
module bplan_txn_calc
    import bplan_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic [BOUND_BITS-1:0] addr_lo,
    input  logic [LEN_W-1:0]      rem,
    input  logic                  tail,
    input  logic                  force_en,
    input  logic [BEATS_W-1:0]    cfg_beats,
    output kind_e                 kind,
    output logic [BEATS_W-1:0]    beats,
    output logic [SPAN_W-1:0]     span_bytes,
    output logic [LEN_W-1:0]      used_bytes,
    output logic [SPAN_W-1:0]     pad_bytes,
    output logic [BEAT_BYTES-1:0] last_be
);
    localparam logic [BOUND_BITS:0] WINDOW = (BOUND_BITS+1)'(1 << BOUND_BITS);

    logic [SPAN_W-1:0]     span_cfg;
    logic [BOUND_BITS:0]   room;
    logic                  fits, multi, rem_full;
    logic [SPAN_W-1:0]     lb_start, used_lo, tail_real;

    always_comb begin
        span_cfg = SPAN_W'({cfg_beats, 2'b00});
        room     = WINDOW - {1'b0, addr_lo};
        fits     = (BOUND_BITS+1)'(span_cfg) <= room;
        multi    = cfg_beats > BEATS_W'(1);
        rem_full = rem >= LEN_W'(span_cfg);

        if (multi && fits && rem_full)             kind = K_BURST;
        else if (multi && fits && force_en && tail) kind = K_FORCED;
        else                                        kind = K_SINGLE;

        case (kind)
            K_BURST: begin
                beats      = cfg_beats;
                span_bytes = span_cfg;
                used_bytes = LEN_W'(span_cfg);
                pad_bytes  = '0;
            end
            K_FORCED: begin
                beats      = cfg_beats;
                span_bytes = span_cfg;
                used_bytes = rem;
                pad_bytes  = span_cfg - SPAN_W'(rem);
            end
            default: begin
                beats      = BEATS_W'(1);
                span_bytes = SPAN_W'(BEAT_BYTES);
                used_bytes = (rem < LEN_W'(BEAT_BYTES)) ? rem : LEN_W'(BEAT_BYTES);
                pad_bytes  = '0;
            end
        endcase

        lb_start  = SPAN_W'({beats - BEATS_W'(1), 2'b00});
        used_lo   = SPAN_W'(used_bytes);
        tail_real = (used_lo > lb_start) ? (used_lo - lb_start) : '0;
        for (int i = 0; i < BEAT_BYTES; i++) begin
            last_be[i] = SPAN_W'(i) < tail_real;
        end
    end
endmodule

// File: rtl/dma_burst_planner.sv
module dma_burst_planner
    import bplan_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [LEN_W-1:0]      req_len,
    input  logic                  req_last,
    input  logic                  req_write,
    input  logic [CODE_W-1:0]     cfg_burst_code,
    input  logic                  cfg_force_max,
    output logic                  txn_valid,
    input  logic                  txn_ready,
    output logic [ADDR_W-1:0]     txn_addr,
    output logic [BEATS_W-1:0]    txn_beats,
    output logic                  txn_incr,
    output logic [BEAT_BYTES-1:0] txn_last_be,
    output logic [SPAN_W-1:0]     txn_pad_bytes,
    output logic                  txn_zero_fill,
    output logic                  txn_discard,
    output logic                  txn_final,
    output logic                  done,
    output logic                  cfg_err
);
    typedef struct packed {
        logic               busy;
        logic [ADDR_W-1:0]  addr;
        logic [LEN_W-1:0]   rem;
        logic               tail;
        logic               write;
        logic               force_en;
        logic [BEATS_W-1:0] cfg_beats;
        logic               err;
        logic               done;
    } state_t;

    state_t st_d, st_q;

    logic [BEATS_W-1:0] dec_beats;
    logic               dec_legal;
    kind_e              kind;
    logic [BEATS_W-1:0] plan_beats;
    logic [SPAN_W-1:0]  plan_span, plan_pad;
    logic [LEN_W-1:0]   plan_used;
    logic [BEAT_BYTES-1:0] plan_be;

    bplan_code_decode u_decode (
        .code  (cfg_burst_code),
        .beats (dec_beats),
        .legal (dec_legal)
    );

    bplan_txn_calc #(.LEN_W(LEN_W)) u_calc (
        .addr_lo    (st_q.addr[BOUND_BITS-1:0]),
        .rem        (st_q.rem),
        .tail       (st_q.tail),
        .force_en   (st_q.force_en),
        .cfg_beats  (st_q.cfg_beats),
        .kind       (kind),
        .beats      (plan_beats),
        .span_bytes (plan_span),
        .used_bytes (plan_used),
        .pad_bytes  (plan_pad),
        .last_be    (plan_be)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy && req_valid) begin
            st_d.addr      = req_addr;
            st_d.rem       = req_len;
            st_d.tail      = req_last;
            st_d.write     = req_write;
            st_d.force_en  = cfg_force_max;
            st_d.cfg_beats = dec_beats;
            if (!dec_legal) st_d.err = 1'b1;
            if (req_len == '0) st_d.done = 1'b1;
            else               st_d.busy = 1'b1;
        end
        if (st_q.busy && txn_ready) begin
            st_d.addr = st_q.addr + ADDR_W'(plan_span);
            st_d.rem  = st_q.rem - plan_used;
            if (st_q.rem == plan_used) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_ready     = !st_q.busy;
    assign txn_valid     = st_q.busy;
    assign txn_addr      = st_q.addr;
    assign txn_beats     = plan_beats;
    assign txn_incr      = kind != K_SINGLE;
    assign txn_last_be   = plan_be;
    assign txn_pad_bytes = plan_pad;
    assign txn_zero_fill = (kind == K_FORCED) && st_q.write;
    assign txn_discard   = (kind == K_FORCED) && !st_q.write;
    assign txn_final     = plan_used == st_q.rem;
    assign done          = st_q.done;
    assign cfg_err       = st_q.err;

    a_r9_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && !txn_ready |=> txn_valid && $stable(txn_addr) && $stable(txn_beats)
            && $stable(txn_last_be) && $stable(txn_pad_bytes));

    a_r6_no_boundary_cross: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && txn_incr |->
            (int'(txn_addr[BOUND_BITS-1:0]) + int'(txn_beats) * BEAT_BYTES) <= (1 << BOUND_BITS));

    a_r1_beat_values: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> (txn_incr ? (txn_beats == 5'd4 || txn_beats == 5'd8 || txn_beats == 5'd16)
                                : (txn_beats == 5'd1)));

    a_r4_pad_only_final: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && (txn_pad_bytes != '0) |-> txn_incr && txn_final);

    a_r5_fill_modes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> !(txn_zero_fill && txn_discard));

    a_r10_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !txn_valid);

    a_r10_done_after_final: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && txn_ready && txn_final |=> done && req_ready);

    a_r2_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);
endmodule

// File: tb/dma_burst_planner_test.sv
module dma_burst_planner_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [15:0] req_len = '0;
    logic        req_last = 1'b0;
    logic        req_write = 1'b0;
    logic [4:0]  cfg_burst_code = 5'd4;
    logic        cfg_force_max = 1'b0;
    logic        txn_valid;
    logic        txn_ready = 1'b0;
    logic [31:0] txn_addr;
    logic [4:0]  txn_beats;
    logic        txn_incr;
    logic [3:0]  txn_last_be;
    logic [6:0]  txn_pad_bytes;
    logic        txn_zero_fill, txn_discard, txn_final, done, cfg_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit exp_err = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    dma_burst_planner uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_len(req_len), .req_last(req_last), .req_write(req_write),
        .cfg_burst_code(cfg_burst_code), .cfg_force_max(cfg_force_max),
        .txn_valid(txn_valid), .txn_ready(txn_ready), .txn_addr(txn_addr),
        .txn_beats(txn_beats), .txn_incr(txn_incr), .txn_last_be(txn_last_be),
        .txn_pad_bytes(txn_pad_bytes), .txn_zero_fill(txn_zero_fill),
        .txn_discard(txn_discard), .txn_final(txn_final),
        .done(done), .cfg_err(cfg_err)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int code_beats(input int code);
        if (code == 4 || code == 8 || code == 16) return code;
        return 1;
    endfunction

    // Run one request and check every transaction against the requirement model
    task automatic run_req(input int addr, input int len, input bit last, input bit wr,
                           input int code, input bit frc);
        int m_addr, m_rem, b, room, e_beats, e_used, e_pad, e_tail, e_be, cyc;
        bit e_incr, e_forced, e_final;
        @(negedge clk);
        chk(req_ready == 1'b1, "R10 ready while idle", req_ready, 1);
        req_valid = 1'b1; req_addr = addr; req_len = 16'(len); req_last = last;
        req_write = wr; cfg_burst_code = 5'(code); cfg_force_max = frc;
        if (code_beats(code) == 1 && code != 1) exp_err = 1;
        @(negedge clk);
        req_valid = 1'b0;
        m_addr = addr; m_rem = len; b = code_beats(code);
        if (len == 0) begin
            chk(done == 1'b1 && txn_valid == 1'b0, "R10 zero length done", done, 1);
        end else begin
            cyc = 0;
            while (m_rem > 0 && cyc < 5000) begin
                cyc++;
                if (!txn_valid) begin
                    chk(0, "R10 txn_valid missing", 0, 1);
                    break;
                end
                txn_ready = ($urandom % 4) != 0;
                if (txn_ready) begin
                    room = 1024 - (m_addr % 1024);
                    e_forced = 0;
                    if (b > 1 && b * 4 <= room && m_rem >= b * 4) begin
                        e_beats = b; e_incr = 1; e_used = b * 4; e_pad = 0;
                    end else if (b > 1 && b * 4 <= room && frc && last) begin
                        e_beats = b; e_incr = 1; e_used = m_rem; e_pad = b * 4 - m_rem;
                        e_forced = 1;
                    end else begin
                        e_beats = 1; e_incr = 0; e_used = (m_rem < 4) ? m_rem : 4; e_pad = 0;
                    end
                    e_tail = e_used - (e_beats - 1) * 4;
                    e_be = (e_tail <= 0) ? 0 : ((1 << e_tail) - 1);
                    e_final = (e_used == m_rem);
                    chk(txn_addr == 32'(m_addr), "R8 txn_addr", txn_addr, m_addr);
                    chk(txn_beats == 5'(e_beats) && txn_incr == e_incr, "R3 beats/type",
                        {txn_incr, txn_beats}, {e_incr, 5'(e_beats)});
                    chk(txn_pad_bytes == 7'(e_pad), "R4 pad bytes", txn_pad_bytes, e_pad);
                    chk(txn_zero_fill == (e_forced && wr) && txn_discard == (e_forced && !wr),
                        "R5 fill/discard", {txn_zero_fill, txn_discard}, {e_forced && wr, e_forced && !wr});
                    chk(txn_last_be == 4'(e_be), "R7 last byte enables", txn_last_be, e_be);
                    chk(txn_final == e_final, "R8 final flag", txn_final, e_final);
                    m_addr += e_beats * 4;
                    m_rem  -= e_used;
                end
                @(negedge clk);
            end
            txn_ready = 1'b0;
            chk(done == 1'b1 && txn_valid == 1'b0, "R10 done pulse after final", done, 1);
        end
        chk(cfg_err == exp_err, "R2 sticky error flag", cfg_err, exp_err);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(req_ready == 1'b1 && txn_valid == 1'b0 && done == 1'b0 && cfg_err == 1'b0,
            "R11 reset outputs", {req_ready, txn_valid, done, cfg_err}, 4'b1000);
        rst_n = 1'b1;

        // Directed corner cases
        run_req(32'h100, 64, 0, 0, 16, 0);   // R1 exactly one 16-beat burst
        run_req(32'h3F0, 64, 0, 1, 8, 0);    // R3 burst would cross 1 KB -> singles
        run_req(32'h200, 5, 1, 1, 8, 1);     // R4 R5 forced write, zero fill, last beat all pad
        run_req(32'h200, 5, 1, 0, 8, 1);     // R5 forced read, residue discarded
        run_req(32'h3F8, 6, 1, 1, 4, 1);     // R6 forced burst would cross -> singles
        run_req(32'h40, 13, 0, 1, 4, 1);     // R4 not tail -> no forcing
        run_req(32'h80, 7, 1, 1, 1, 1);      // R1 single mode ignores forcing
        run_req(32'h0, 0, 1, 0, 4, 0);       // R10 zero length

        // Random mix of legal codes, near-boundary addresses and lengths
        for (int i = 0; i < 400; i++) begin
            int cs[4] = '{1, 4, 8, 16};
            int a, l;
            a = ($urandom % 2) ? int'(($urandom % 65536) * 4)
                               : int'(1024 * ($urandom % 64 + 1) - 4 * ($urandom % 24));
            l = ($urandom % 10 == 0) ? int'($urandom % 8) : int'($urandom % 300);
            run_req(a, l, 1'($urandom), 1'($urandom), cs[$urandom % 4], 1'($urandom));
        end

        // R2 reserved and invalid codes: singles and sticky error
        run_req(32'h400, 20, 1, 1, 2, 1);
        run_req(32'h400, 12, 0, 0, 0, 0);
        run_req(32'h800, 40, 1, 0, 12, 1);
        run_req(32'h800, 40, 0, 0, 4, 0);    // legal code afterwards, error stays

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule